// File: doc/BRIEF.md
# Two-Segment Overlapped Search Scheduler

This block feeds search keys to a content-addressable array whose per-word comparison is split into two segments. The first segment looks only at the low sub-key of each key. The second segment looks at the remaining high bits, and only for the words whose first segment matched. Each segment takes one precharge cycle followed by one evaluate cycle. A word that fails in the first segment is finished as a miss, and its second-segment match node is never precharged. The array itself is modelled behaviourally as a small binary CAM with contents fixed by a parameter.

Keys arrive on a valid/ready port and wait in a four-entry lookahead queue. Each accepted key receives a sequence tag. The next key may enter the first segment while the previous key is still in the second segment, but only if their sub-keys differ (fast mode). When the key at the head of the queue would collide with the key ahead of it, the scheduler searches the queue for the first entry with a different sub-key and swaps it with the head. If every waiting key collides, order is kept and the next key waits until the pipeline is empty (slow mode). Results leave on a valid/ready port carrying the tag, so a consumer can restore the arrival order. When the input goes quiet, the queue drains on its own.

Top module: `rso_sched`

## Requirements
- R1: `key_ready_o` is high whenever fewer than four keys wait in the queue. Accepted keys get tags 0, 1, 2, … (modulo 16) from reset. Every result echoes the key that carried its tag.
- R2: `res_hit_o[w]` is 1 exactly when stored word w equals the result key in all four bits. The stored words are 4'h3, 4'h6, 4'hA and 4'hF for w = 0..3.
- R3: `seg2_pchg_o[w]` is asserted only for words whose low two bits equal the key's low two bits. It is asserted in one cycle per key, and never for a key that matches no word in its low bits.
- R4: Each segment spends exactly one precharge cycle and one evaluate cycle per key. `seg1_pchg_o` is all ones for one cycle per key. On an idle pipeline, the result appears on the fifth rising edge after the edge that accepted the key.
- R5: For keys whose consecutive low sub-keys differ, the two segments overlap and results come out every 2 cycles. `ovl_o` is high while both segments hold keys, and keys that overlap always have different sub-keys.
- R6: If every waiting key has the same sub-key as the key in flight, the next key enters the first segment only after the previous key has left the second segment. Results are then 5 cycles apart and `ovl_o` stays low.
- R7: If the head key collides with the key in flight, the lowest-positioned queued key with a different sub-key is issued instead, and the old head takes its queue slot. For the key sequence 0, 4, 8, 1, 5, results leave in tag-offset order 0, 3, 2, 4, 1.
- R8: Once the input stops, every accepted key produces exactly one result.
- R9: While `res_ready_i` is low, a pending result holds its tag and key stable. At most seven keys are accepted: four in the queue and three in flight.
- R10: After reset, `key_ready_o` is high and `res_valid_o`, `seg1_pchg_o`, `seg2_pchg_o` and `ovl_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | Search key offered |
| key_i | input | 4 | Search key |
| key_ready_o | output | 1 | Queue can take a key |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_tag_o | output | 4 | Sequence tag of the result |
| res_key_o | output | 4 | Key that was searched |
| res_hit_o | output | 4 | Per-word hit vector |
| seg1_pchg_o | output | 4 | First-segment precharge per word |
| seg2_pchg_o | output | 4 | Second-segment precharge per word |
| ovl_o | output | 1 | Both segments busy in the same cycle |

## Verification
An exhaustive sweep of all sixteen keys, each sent alone, separates correct full-word hits from first-segment-only hits. The same sweep confirms that second-segment precharge follows the low-bit match and that latency is fixed. A stream of alternating sub-keys and a stream of identical sub-keys tell fast mode from slow mode, through the spacing of results and through `ovl_o`. A mixed stream with colliding heads checks the swap order exactly. A run with the consumer stalled shows that exactly seven keys are accepted, and that the drain afterwards returns every tag once.

// File: rtl/rso_pkg.sv
package rso_pkg;
  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_EVAL = 1'b1
  } phase_e;
endpackage

// File: rtl/rso_rstsync.sv
module rso_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rso_seg.sv
// One comparison segment: a precharge cycle, then an evaluate cycle.
// Only enabled words are precharged and evaluated.
module rso_seg
  import rso_pkg::*;
#(
  parameter int KW = 4,
  parameter int TW = 4,
  parameter int NW = 4,
  parameter int LO = 0,
  parameter int HI = 1,
  parameter logic [NW*KW-1:0] CAM = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [KW-1:0] in_key,
  input  logic [TW-1:0] in_tag,
  input  logic [NW-1:0] in_en,
  output logic          in_rdy,
  input  logic          dn_rdy,
  output logic          vld,
  output logic [KW-1:0] key,
  output logic [TW-1:0] tag,
  output logic          done,
  output logic [NW-1:0] pchg,
  output logic [NW-1:0] match
);
  localparam int SW = HI - LO + 1;

  logic          vld_q, vld_n;
  phase_e        ph_q, ph_n;
  logic [KW-1:0] key_q;
  logic [TW-1:0] tag_q;
  logic [NW-1:0] en_q;
  logic [NW-1:0] eq;
  logic          adv, load;

  assign done   = vld_q && (ph_q == PH_EVAL);
  assign adv    = done && dn_rdy;
  assign in_rdy = !vld_q || adv;
  assign load   = in_vld && in_rdy;

  always_comb begin
    vld_n = vld_q;
    ph_n  = ph_q;
    if (load) begin
      vld_n = 1'b1;
      ph_n  = PH_PRE;
    end else if (adv) begin
      vld_n = 1'b0;
    end else if (vld_q && ph_q == PH_PRE) begin
      ph_n = PH_EVAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ph_q  <= PH_PRE;
    end else begin
      vld_q <= vld_n;
      ph_q  <= ph_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      key_q <= in_key;
      tag_q <= in_tag;
      en_q  <= in_en;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign eq[w] = (CAM[w*KW+LO +: SW] == key_q[LO +: SW]);
  end

  assign pchg  = (vld_q && ph_q == PH_PRE) ? en_q : '0;
  assign match = done ? (en_q & eq) : '0;
  assign vld   = vld_q;
  assign key   = key_q;
  assign tag   = tag_q;

  AST_PRE_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && ph_q == PH_PRE) |=> (vld_q && ph_q == PH_EVAL)); // R4

  AST_EVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dn_rdy) |=> (done && $stable(key_q) && $stable(tag_q))); // R9
endmodule

// File: rtl/rso_lookq.sv
// Lookahead queue: picks the first waiting key whose sub-key differs from
// the key in flight and swaps it with the head.
module rso_lookq #(
  parameter int KW    = 4,
  parameter int TW    = 4,
  parameter int SW    = 2,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_vld,
  input  logic [KW-1:0] push_key,
  output logic          push_rdy,
  input  logic          ref_vld,
  input  logic [SW-1:0] ref_sub,
  input  logic          pipe_idle,
  output logic          iss_vld,
  output logic [KW-1:0] iss_key,
  output logic [TW-1:0] iss_tag,
  input  logic          iss_take
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [KW-1:0] key_q [DEPTH];
  logic [TW-1:0] tag_q [DEPTH];
  logic [KW-1:0] key_n [DEPTH];
  logic [TW-1:0] tag_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n, cnt_mid;
  logic [TW-1:0] seq_q, seq_n;
  logic [DEPTH-1:0] diff;
  logic          any_diff;
  logic [IW-1:0] first_diff, sel;
  logic          push;

  assign push_rdy = (cnt_q < DEPTH_C);
  assign push     = push_vld && push_rdy;

  always_comb begin
    for (int j = 0; j < DEPTH; j++)
      diff[j] = (CW'(j) < cnt_q) && (key_q[j][SW-1:0] != ref_sub);
    any_diff   = |diff;
    first_diff = '0;
    for (int j = DEPTH - 1; j >= 0; j--)
      if (diff[j]) first_diff = IW'(j);
  end

  assign sel     = (ref_vld && any_diff) ? first_diff : '0;
  assign iss_vld = (cnt_q != '0) && (!ref_vld || any_diff || pipe_idle);
  assign iss_key = key_q[sel];
  assign iss_tag = tag_q[sel];

  always_comb begin
    cnt_mid = cnt_q - CW'(iss_take);
    for (int i = 0; i < DEPTH; i++) begin
      key_n[i] = key_q[i];
      tag_n[i] = tag_q[i];
    end
    if (iss_take) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i + 1 == int'(sel)) begin
          key_n[i] = key_q[0];
          tag_n[i] = tag_q[0];
        end else begin
          key_n[i] = key_q[i+1];
          tag_n[i] = tag_q[i+1];
        end
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push && CW'(i) == cnt_mid) begin
        key_n[i] = push_key;
        tag_n[i] = seq_q;
      end
    end
    cnt_n = cnt_mid + CW'(push);
    seq_n = push ? seq_q + TW'(1) : seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seq_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      seq_q <= seq_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push || iss_take) begin
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= key_n[i];
        tag_q[i] <= tag_n[i];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C); // R1

  AST_TAKE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    iss_take |-> iss_vld); // R8

  AST_ISSUE_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_take && !pipe_idle) |-> (iss_key[SW-1:0] != ref_sub)); // R7
endmodule

// File: rtl/rso_sched.sv
module rso_sched
  import rso_pkg::*;
#(
  parameter int KW   = 4,
  parameter int SUBW = 2,
  parameter int LOOK = 3,
  parameter int NW   = 4,
  parameter int TW   = 4,
  parameter logic [NW*KW-1:0] CAM = 16'hFA63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid_i,
  input  logic [KW-1:0] key_i,
  output logic          key_ready_o,
  output logic          res_valid_o,
  input  logic          res_ready_i,
  output logic [TW-1:0] res_tag_o,
  output logic [KW-1:0] res_key_o,
  output logic [NW-1:0] res_hit_o,
  output logic [NW-1:0] seg1_pchg_o,
  output logic [NW-1:0] seg2_pchg_o,
  output logic          ovl_o
);
  localparam int DEPTH = LOOK + 1;
  localparam int NSEG  = 2;

  logic          rst_i_n;
  logic          iss_vld;
  logic [KW-1:0] iss_key;
  logic [TW-1:0] iss_tag;
  logic          iss_take;
  logic          ref_vld, pipe_idle;
  logic [SUBW-1:0] ref_sub;

  logic          s_in_vld [NSEG];
  logic [KW-1:0] s_in_key [NSEG];
  logic [TW-1:0] s_in_tag [NSEG];
  logic [NW-1:0] s_in_en  [NSEG];
  logic          s_in_rdy [NSEG];
  logic          s_dn_rdy [NSEG];
  logic          s_vld    [NSEG];
  logic [KW-1:0] s_key    [NSEG];
  logic [TW-1:0] s_tag    [NSEG];
  logic          s_done   [NSEG];
  logic [NW-1:0] s_pchg   [NSEG];
  logic [NW-1:0] s_match  [NSEG];

  logic          out_vld_q, out_vld_n, out_load;
  logic [TW-1:0] out_tag_q;
  logic [KW-1:0] out_key_q;
  logic [NW-1:0] out_hit_q;

  rso_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  // Collision reference: the key that the next issue would overlap with.
  assign ref_vld   = s_vld[0] || s_vld[1];
  assign ref_sub   = s_vld[0] ? s_key[0][SUBW-1:0] : s_key[1][SUBW-1:0];
  assign pipe_idle = !s_vld[0] && !s_vld[1];
  assign iss_take  = iss_vld && s_in_rdy[0];

  rso_lookq #(.KW(KW), .TW(TW), .SW(SUBW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_i_n),
    .push_vld(key_valid_i), .push_key(key_i), .push_rdy(key_ready_o),
    .ref_vld(ref_vld), .ref_sub(ref_sub), .pipe_idle(pipe_idle),
    .iss_vld(iss_vld), .iss_key(iss_key), .iss_tag(iss_tag),
    .iss_take(iss_take)
  );

  assign s_in_vld[0] = iss_vld;
  assign s_in_key[0] = iss_key;
  assign s_in_tag[0] = iss_tag;
  assign s_in_en[0]  = '1;
  assign s_dn_rdy[0] = s_in_rdy[1];

  assign s_in_vld[1] = s_done[0];
  assign s_in_key[1] = s_key[0];
  assign s_in_tag[1] = s_tag[0];
  assign s_in_en[1]  = s_match[0];
  assign s_dn_rdy[1] = !out_vld_q || res_ready_i;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO_G = (g == 0) ? 0 : SUBW;
    localparam int HI_G = (g == 0) ? SUBW - 1 : KW - 1;
    rso_seg #(
      .KW(KW), .TW(TW), .NW(NW), .LO(LO_G), .HI(HI_G), .CAM(CAM)
    ) u_seg (
      .clk(clk), .rst_n(rst_i_n),
      .in_vld(s_in_vld[g]), .in_key(s_in_key[g]), .in_tag(s_in_tag[g]),
      .in_en(s_in_en[g]), .in_rdy(s_in_rdy[g]), .dn_rdy(s_dn_rdy[g]),
      .vld(s_vld[g]), .key(s_key[g]), .tag(s_tag[g]), .done(s_done[g]),
      .pchg(s_pchg[g]), .match(s_match[g])
    );
  end

  assign out_load = s_done[1] && s_dn_rdy[1];

  always_comb begin
    out_vld_n = out_vld_q;
    if (out_load)         out_vld_n = 1'b1;
    else if (res_ready_i) out_vld_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_vld_q <= 1'b0;
    else          out_vld_q <= out_vld_n;
  end

  always_ff @(posedge clk) begin
    if (out_load) begin
      out_tag_q <= s_tag[1];
      out_key_q <= s_key[1];
      out_hit_q <= s_match[1];
    end
  end

  assign res_valid_o = out_vld_q;
  assign res_tag_o   = out_tag_q;
  assign res_key_o   = out_key_q;
  assign res_hit_o   = out_hit_q;
  assign seg1_pchg_o = s_pchg[0];
  assign seg2_pchg_o = s_pchg[1];
  assign ovl_o       = s_vld[0] && s_vld[1];

  AST_OVERLAP_SUBKEY_DIFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    ovl_o |-> (s_key[0][SUBW-1:0] != s_key[1][SUBW-1:0])); // R5

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_tag_o) && $stable(res_key_o))); // R9

  for (genvar w = 0; w < NW; w++) begin : g_chk
    AST_SEG2_PCHG_GATED: assert property (@(posedge clk) disable iff (!rst_i_n)
      seg2_pchg_o[w] |-> (CAM[w*KW +: SUBW] == s_key[1][SUBW-1:0])); // R3
    AST_HIT_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_i_n)
      (res_valid_o && res_hit_o[w]) |-> (CAM[w*KW +: KW] == res_key_o)); // R2
  end
endmodule

// File: tb/rso_sched_tb.sv
module rso_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0;
  logic [3:0] key_in = '0;
  logic       res_ready = 1'b1;
  logic       key_ready, res_valid, ovl;
  logic [3:0] res_tag, res_key, res_hit, pchg1, pchg2;

  always #2.5 clk = ~clk;

  rso_sched u_dut (
    .clk(clk), .rst_n(rst_n), .key_valid_i(key_valid), .key_i(key_in),
    .key_ready_o(key_ready), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_tag_o(res_tag), .res_key_o(res_key), .res_hit_o(res_hit),
    .seg1_pchg_o(pchg1), .seg2_pchg_o(pchg2), .ovl_o(ovl)
  );

  int checks = 0, fails = 0, cyc = 0, exp_tag = 0, nres = 0, acc_cyc = 0;
  int rec_tag [64];
  int rec_cyc [64];
  logic [3:0] sent_key [16];
  int p1_cnt = 0, p2_cnt = 0;
  logic [3:0] p2_or = '0;
  bit ovl_seen = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cam_w(input int w);
    return 4'((16'hFA63 >> (4 * w)) & 16'hF);
  endfunction

  function automatic logic [3:0] exp_hit(input logic [3:0] k);
    logic [3:0] h;
    for (int w = 0; w < 4; w++) h[w] = (cam_w(w) == k);
    return h;
  endfunction

  function automatic logic [3:0] exp_low(input logic [3:0] k);
    logic [3:0] h;
    for (int w = 0; w < 4; w++) h[w] = (cam_w(w) & 4'h3) == (k & 4'h3);
    return h;
  endfunction

  // Result and observation monitor, sampled well away from the clock edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (pchg1 != 0) begin
        p1_cnt++;
        chk(pchg1 == 4'hF, "R4 seg1 precharge all words", int'(pchg1), 15);
      end
      if (pchg2 != 0) begin
        p2_cnt++;
        p2_or |= pchg2;
      end
      if (ovl) ovl_seen = 1;
      if (res_valid && res_ready && nres < 64) begin
        rec_tag[nres] = int'(res_tag);
        rec_cyc[nres] = cyc;
        chk(res_hit == exp_hit(res_key), "R2 hit vector", int'(res_hit), int'(exp_hit(res_key)));
        chk(res_key == sent_key[res_tag], "R1 key echo for tag", int'(res_key), int'(sent_key[res_tag]));
        nres++;
      end
    end
  end

  task automatic send(input logic [3:0] k);
    key_valid = 1'b1;
    key_in = k;
    while (!key_ready) @(negedge clk);
    sent_key[exp_tag] = k;
    acc_cyc = cyc + 1;
    exp_tag = (exp_tag + 1) % 16;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic wait_res(input int n);
    for (int i = 0; i < 300 && nres < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int base, tag0, acc;
    int ord [5];
    logic [15:0] seen;
    ord = '{0, 3, 2, 4, 1};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk(key_ready == 1'b1, "R10 key_ready after reset", int'(key_ready), 1);
    chk(res_valid == 1'b0, "R10 res_valid after reset", int'(res_valid), 0);
    chk(pchg1 == 0 && pchg2 == 0, "R10 precharge idle", int'({pchg1, pchg2}), 0);
    chk(ovl == 1'b0, "R10 overlap idle", int'(ovl), 0);

    // Exhaustive single-key sweep: R1 R2 R3 R4
    for (int k = 0; k < 16; k++) begin
      p1_cnt = 0; p2_cnt = 0; p2_or = '0;
      base = nres;
      send(4'(k));
      wait_res(base + 1);
      chk(nres == base + 1, "R8 single result", nres - base, 1);
      chk(rec_tag[base] == k, "R1 tag sequence", rec_tag[base], k);
      chk(rec_cyc[base] - acc_cyc == 5, "R4 idle latency", rec_cyc[base] - acc_cyc, 5);
      chk(p1_cnt == 1, "R4 seg1 precharge cycles", p1_cnt, 1);
      chk(p2_cnt == ((exp_low(4'(k)) != 0) ? 1 : 0), "R3 seg2 precharge cycles",
          p2_cnt, (exp_low(4'(k)) != 0) ? 1 : 0);
      chk(p2_or == exp_low(4'(k)), "R3 seg2 precharge words", int'(p2_or), int'(exp_low(4'(k))));
    end

    // Fast mode, alternating sub-keys: R5
    ovl_seen = 0; base = nres; tag0 = exp_tag;
    send(4'h0); send(4'h1); send(4'h4); send(4'h5); send(4'h8); send(4'h9);
    wait_res(base + 6);
    chk(nres == base + 6, "R8 fast drain count", nres - base, 6);
    for (int i = 1; i < 6; i++)
      chk(rec_cyc[base+i] - rec_cyc[base+i-1] == 2, "R5 fast spacing",
          rec_cyc[base+i] - rec_cyc[base+i-1], 2);
    for (int i = 0; i < 6; i++)
      chk(rec_tag[base+i] == (tag0 + i) % 16, "R5 fast order", rec_tag[base+i], (tag0 + i) % 16);
    chk(ovl_seen == 1, "R5 overlap observed", int'(ovl_seen), 1);

    // Slow mode, identical sub-keys: R6
    ovl_seen = 0; base = nres; tag0 = exp_tag;
    send(4'h3); send(4'h7); send(4'hB); send(4'hF);
    wait_res(base + 4);
    chk(nres == base + 4, "R8 slow drain count", nres - base, 4);
    for (int i = 1; i < 4; i++)
      chk(rec_cyc[base+i] - rec_cyc[base+i-1] == 5, "R6 slow spacing",
          rec_cyc[base+i] - rec_cyc[base+i-1], 5);
    for (int i = 0; i < 4; i++)
      chk(rec_tag[base+i] == (tag0 + i) % 16, "R6 slow order", rec_tag[base+i], (tag0 + i) % 16);
    chk(ovl_seen == 0, "R6 no overlap", int'(ovl_seen), 0);

    // Reordering by swap: R7
    base = nres; tag0 = exp_tag;
    send(4'h0); send(4'h4); send(4'h8); send(4'h1); send(4'h5);
    wait_res(base + 5);
    chk(nres == base + 5, "R8 reorder drain count", nres - base, 5);
    for (int i = 0; i < 5; i++)
      chk(rec_tag[base+i] == (tag0 + ord[i]) % 16, "R7 swap order",
          rec_tag[base+i], (tag0 + ord[i]) % 16);

    // Backpressure: R9, then drain R8
    base = nres; tag0 = exp_tag; acc = 0;
    res_ready = 1'b0;
    key_valid = 1'b1;
    key_in = 4'(acc);
    for (int c = 0; c < 30; c++) begin
      if (key_ready) begin
        sent_key[exp_tag] = key_in;
        exp_tag = (exp_tag + 1) % 16;
        acc++;
      end
      @(negedge clk);
      key_in = 4'(acc);
    end
    key_valid = 1'b0;
    chk(acc == 7, "R9 keys accepted while stalled", acc, 7);
    chk(res_valid == 1'b1, "R9 result pending", int'(res_valid), 1);
    chk(int'(res_tag) == tag0, "R9 held tag", int'(res_tag), tag0);
    chk(key_ready == 1'b0, "R1 ready low when full", int'(key_ready), 0);
    res_ready = 1'b1;
    wait_res(base + acc);
    chk(nres == base + 7, "R8 stalled drain count", nres - base, 7);
    seen = '0;
    for (int i = base; i < nres; i++) seen[rec_tag[i]] = 1'b1;
    for (int i = 0; i < 7; i++)
      chk(seen[(tag0 + i) % 16] == 1'b1, "R8 tag returned", int'(seen[(tag0 + i) % 16]), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule